// File: doc/BRIEF.md
# Serial Configuration Slave with Read Lock

This block is the configuration port of a sensor signal chain. An external master talks to it over a three-signal serial link: a clock, an active-low select and one shared data line. Every transaction is a 16-bit frame made of a command byte followed by a data byte, most significant bit first. The slave sets a handful of configuration fields from the frames it receives and drives them as parallel outputs. These outputs are the two gain-stage enables, the external filter routing, the common-mode select, the two gain selects and an 8-bit offset code.

Writes are always accepted. Reads stay blocked after reset. They open only when the master writes the key byte 0xFE and then the key byte 0xED, in consecutive completed writes to the mode register at address 0xF. During a read, the shared data line changes direction halfway through the frame. The slave drives the line from the falling clock edge that follows the command byte and releases it at the end of the frame. All three link signals pass through two-flop synchronisers into a system clock that runs at least eight times faster than the serial clock. The pad itself is outside the block: the slave provides a data-out bit and an output enable for it.

Top module: `cfgspi_slave`

## Requirements
- R1: After reset, every configuration field is 0, the offset code is 0x80 and the data output enable is low.
- R2: A command byte with bit 7 = 0 is a write, and bits 3:0 give the address. A write to address 0x0 sets bit 6 = second-stage enable, bit 5 = first-stage enable, bit 4 = external filter routing, bit 3 = common-mode select, bits 2:1 = second-stage gain and bit 0 = first-stage gain. Bit 7 of that register always stays 0.
- R3: A write to address 0x1 sets the 8-bit offset code.
- R4: A write takes effect only after all 16 bits have arrived. A frame cut short by CSB rising changes nothing.
- R5: After reset, a read command (bit 7 = 1) never enables the data output.
- R6: Reads open after 0xFE and then 0xED are written to address 0xF. An open read of address 0x0 or 0x1 drives the register from the falling edge after the 8th rising edge, MSB first, so that it is valid at rising edges 9 to 16.
- R7: Any completed write of another value to 0xF closes reads. Writing 0xFE followed by a different value, or writing 0xED with no 0xFE before it, leaves reads closed.
- R8: The output enable drops after the 16th rising edge, and it drops at once when CSB rises in the middle of a read.
- R9: Reads of 0xF or of an unmapped address leave the line undriven. Writes to unmapped addresses change no output.
- R10: With CSB held low, back-to-back frames are decoded one after another.
- R11: A fall of CSB always starts a new frame at bit 0, even after an aborted frame.
- R12: Once reads are open, any number of reads may follow. An aborted frame to 0xF neither advances nor resets the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| csb_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Data line value seen at the pad |
| sdio_o | output | 1 | Data bit the slave drives during a read |
| sdio_oe | output | 1 | Pad output enable for the data line |
| stage2_en | output | 1 | Second gain stage enable |
| stage1_en | output | 1 | First gain stage enable |
| filt_ext | output | 1 | Route the signal through the external filter |
| cm_hi | output | 1 | Common-mode level select |
| g2_sel | output | 2 | Second-stage gain select |
| g1_sel | output | 1 | First-stage gain select |
| ofs_code | output | 8 | Offset DAC code |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, two synchroniser stages, keys 0xFE and 0xED, and an offset reset value of 0x80. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchroniser and edge-detect latency between each serial edge and the moment the slave reacts to it. Under these values the bench can reach every state of the lock sequence. It also reaches aborted frames in both halves of a frame, reads that are cut off while the slave is driving, and frames that run back to back under a select held low.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 4;
  localparam logic [ADR_W-1:0] ADR_CFG  = 4'h0;
  localparam logic [ADR_W-1:0] ADR_OFS  = 4'h1;
  localparam logic [ADR_W-1:0] ADR_MODE = 4'hF;
  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hFE;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hED;

  typedef enum logic [1:0] {LK_CLOSED, LK_ARMED, LK_OPEN} lock_e;

  typedef struct packed {
    logic             rd;
    logic [ADR_W-1:0] adr;
  } cmd_t;

  // Split a command byte: MSB is the direction, low nibble the address.
  function automatic cmd_t cmd_decode(input logic [BYTE_W-1:0] c);
    cmd_t r;
    r.rd  = c[BYTE_W-1];
    r.adr = c[ADR_W-1:0];
    return r;
  endfunction

  // Unlock tracker step for one completed write to the mode register.
  function automatic lock_e lock_next(input lock_e s, input logic [BYTE_W-1:0] d);
    if (d == KEY_FIRST)                          return LK_ARMED;
    else if (d == KEY_SECOND && s == LK_ARMED)   return LK_OPEN;
    else                                         return LK_CLOSED;
  endfunction

  function automatic logic adr_readable(input logic [ADR_W-1:0] a);
    return (a == ADR_CFG) || (a == ADR_OFS);
  endfunction
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfgspi_rx.sv
module cfgspi_rx #(
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = 2 * DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csb_s,
  input  logic              sdio_s,
  output logic              sclk_fall,
  output logic              cmd_done,
  output logic              frame_done,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic              sclk_d;
  logic              sclk_rise;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  // Edges count only while the frame is selected.
  assign sclk_rise = sclk_s & ~sclk_d & ~csb_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~csb_s;
  assign sh_next   = {sh[DATA_W-2:0], sdio_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh         <= '0;
      cmd_q      <= '0;
      data_q     <= '0;
      cmd_done   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      cmd_done   <= 1'b0;
      frame_done <= 1'b0;
      if (csb_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        sh <= sh_next;
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          bit_cnt    <= '0;
          data_q     <= sh_next;
          frame_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(DATA_W - 1)) begin
            cmd_q    <= sh_next;
            cmd_done <= 1'b1;
          end
        end
      end
    end
  end

  a_r10_frame_end_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> bit_cnt == '0);
  a_r11_idle_counter_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csb_s |=> bit_cnt == '0);
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST = 8'h00,
  parameter logic [BYTE_W-1:0] OFS_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [BYTE_W-1:0] cmd_q,
  input  logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] ofs_q,
  output logic              unlocked,
  output logic              rd_ok,
  output logic [BYTE_W-1:0] rd_val
);
  localparam logic [BYTE_W-1:0] CFG_MASK = {1'b0, {(BYTE_W-1){1'b1}}};

  cmd_t  cmd;
  lock_e lock_q;
  logic  wr_stb;
  logic  wr_mode;

  assign cmd     = cmd_decode(cmd_q);
  assign wr_stb  = frame_done & ~cmd.rd;
  assign wr_mode = wr_stb & (cmd.adr == ADR_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST & CFG_MASK;
      ofs_q  <= OFS_RST;
      lock_q <= LK_CLOSED;
    end else if (wr_stb) begin
      case (cmd.adr)
        ADR_CFG:  cfg_q  <= data_q & CFG_MASK;
        ADR_OFS:  ofs_q  <= data_q;
        ADR_MODE: lock_q <= lock_next(lock_q, data_q);
        default:  ;
      endcase
    end
  end

  assign unlocked = (lock_q == LK_OPEN);

  always_comb begin
    rd_ok  = unlocked & cmd.rd & adr_readable(cmd.adr);
    rd_val = (cmd.adr == ADR_OFS) ? ofs_q : cfg_q;
  end

  a_r2_cfg_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[BYTE_W-1] == 1'b0);
  a_r4_cfg_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(frame_done));
  a_r3_ofs_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ofs_q) |-> $past(frame_done));
  a_r6_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_mode && data_q == KEY_SECOND));
  a_r7_other_value_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && data_q != KEY_FIRST && data_q != KEY_SECOND) |=> !unlocked);
endmodule

// File: rtl/cfgspi_tx.sv
module cfgspi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_s,
  input  logic              sclk_fall,
  input  logic              cmd_done,
  input  logic              frame_done,
  input  logic              load_ok,
  input  logic [DATA_W-1:0] load_val,
  output logic              sdo,
  output logic              oe
);
  logic              active;
  logic [DATA_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      oe     <= 1'b0;
      sdo    <= 1'b0;
      tx_sh  <= '0;
    end else if (csb_s || frame_done) begin
      active <= 1'b0;
      oe     <= 1'b0;
    end else if (cmd_done) begin
      active <= load_ok;
      tx_sh  <= load_val;
    end else if (sclk_fall && active) begin
      oe    <= 1'b1;
      sdo   <= tx_sh[DATA_W-1];
      tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  a_r8_release_on_csb: assert property (@(posedge clk) disable iff (!rst_n)
    csb_s |=> !oe);
  a_r8_release_on_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !oe);
endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
  import cfgspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CFG_RST = 8'h00,
  parameter logic [BYTE_W-1:0] OFS_RST = 8'h80,
  localparam int CNT_W = $clog2(2 * BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csb_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              stage2_en,
  output logic              stage1_en,
  output logic              filt_ext,
  output logic              cm_hi,
  output logic [1:0]        g2_sel,
  output logic              g1_sel,
  output logic [BYTE_W-1:0] ofs_code
);
  logic [2:0]        pins_s;
  logic              sclk_s, csb_s, sdio_s;
  logic              sclk_fall, cmd_done, frame_done;
  logic [BYTE_W-1:0] cmd_q, data_q, cfg_q, rd_val;
  logic [CNT_W-1:0]  bit_cnt;
  logic              unlocked, rd_ok;

  // Idle levels: clock high, select high, data low.
  cfgspi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_i, csb_i, sdio_i}), .q(pins_s)
  );
  assign {sclk_s, csb_s, sdio_s} = pins_s;

  cfgspi_rx #(.DATA_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .csb_s(csb_s), .sdio_s(sdio_s),
    .sclk_fall(sclk_fall), .cmd_done(cmd_done), .frame_done(frame_done),
    .cmd_q(cmd_q), .data_q(data_q), .bit_cnt(bit_cnt)
  );

  cfgspi_regs #(.CFG_RST(CFG_RST), .OFS_RST(OFS_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .cmd_q(cmd_q), .data_q(data_q),
    .cfg_q(cfg_q), .ofs_q(ofs_code), .unlocked(unlocked),
    .rd_ok(rd_ok), .rd_val(rd_val)
  );

  cfgspi_tx #(.DATA_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .csb_s(csb_s), .sclk_fall(sclk_fall),
    .cmd_done(cmd_done), .frame_done(frame_done),
    .load_ok(rd_ok), .load_val(rd_val),
    .sdo(sdio_o), .oe(sdio_oe)
  );

  assign stage2_en = cfg_q[6];
  assign stage1_en = cfg_q[5];
  assign filt_ext  = cfg_q[4];
  assign cm_hi     = cfg_q[3];
  assign g2_sel    = cfg_q[2:1];
  assign g1_sel    = cfg_q[0];

  a_r5_drive_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> unlocked);
  a_r6_drive_in_data_half: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (bit_cnt >= CNT_W'(BYTE_W) || frame_done));
endmodule

// File: tb/cfgspi_slave_tb_top.sv
module cfgspi_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b1, csb_i = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, stage2_en, stage1_en, filt_ext, cm_hi, g1_sel;
  logic [1:0] g2_sel;
  logic [7:0] ofs_code;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgspi_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csb_i(csb_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .stage2_en(stage2_en), .stage1_en(stage1_en),
    .filt_ext(filt_ext), .cm_hi(cm_hi), .g2_sel(g2_sel), .g1_sel(g1_sel),
    .ofs_code(ofs_code)
  );

  function automatic logic [7:0] cfg_now();
    return {1'b0, stage2_en, stage1_en, filt_ext, cm_hi, g2_sel, g1_sel};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One frame of nbits; returns the byte seen at rising edges 9..16,
  // how many of those bits were driven, and the enable after the last edge.
  task automatic frame(input logic [15:0] w, input int nbits, input bit lower, input bit raise,
                       output logic [7:0] rb, output int drv, output logic oe_after);
    rb = '0; drv = 0;
    if (lower) begin csb_i = 1'b0; wt(HALF); end
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b0;
      sdio_i = w[15-i];
      wt(HALF);
      if (i >= 8) begin
        rb = {rb[6:0], sdio_o};
        if (sdio_oe) drv++;
      end
      sclk_i = 1'b1;
      wt(HALF);
    end
    oe_after = sdio_oe;
    if (raise) begin csb_i = 1'b1; wt(HALF); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rb; int drv; logic oe;
    frame({4'h0, a, d}, 16, 1'b1, 1'b1, rb, drv, oe);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v, output int drv, output logic oe);
    frame({4'h8, a, 8'h00}, 16, 1'b1, 1'b1, v, drv, oe);
  endtask

  task automatic t_reset();
    check("R1 cfg", cfg_now(), 8'h00);
    check("R1 ofs", ofs_code, 8'h80);
    check("R1 oe", sdio_oe, 1'b0);
  endtask

  task automatic t_write();
    wr(4'h0, 8'hFF);
    check("R2 top bit dropped", cfg_now(), 8'h7F);
    wr(4'h0, 8'h2B);
    check("R2 cfg", cfg_now(), 8'h2B);
    check("R2 g2 field", g2_sel, 2'b01);
    check("R2 cm field", cm_hi, 1'b1);
    check("R2 stage2 field", stage2_en, 1'b0);
    wr(4'h1, 8'h3C);
    check("R3 ofs", ofs_code, 8'h3C);
  endtask

  task automatic t_locked();
    logic [7:0] v; int drv; logic oe;
    rd(4'h0, v, drv, oe);
    check("R5 locked read driven bits", drv, 0);
  endtask

  task automatic t_bad_keys();
    logic [7:0] v; int drv; logic oe;
    wr(4'hF, 8'hFE); wr(4'hF, 8'h12);
    rd(4'h0, v, drv, oe);
    check("R7 FE then other", drv, 0);
    wr(4'hF, 8'hED);
    rd(4'h1, v, drv, oe);
    check("R7 ED without FE", drv, 0);
  endtask

  task automatic t_unlock();
    logic [7:0] v; int drv; logic oe;
    wr(4'hF, 8'hFE); wr(4'hF, 8'hED);
    rd(4'h0, v, drv, oe);
    check("R6 read cfg value", v, 8'h2B);
    check("R6 read cfg driven", drv, 8);
    check("R8 released after bit 16", oe, 1'b0);
    wr(4'h1, 8'hA5);
    rd(4'h1, v, drv, oe);
    check("R12 second read value", v, 8'hA5);
    check("R12 second read driven", drv, 8);
  endtask

  task automatic t_unmapped();
    logic [7:0] v; int drv; logic oe;
    rd(4'hF, v, drv, oe);
    check("R9 read mode reg", drv, 0);
    rd(4'h6, v, drv, oe);
    check("R9 read unmapped", drv, 0);
    wr(4'h5, 8'hFF);
    check("R9 unmapped write cfg", cfg_now(), 8'h2B);
    check("R9 unmapped write ofs", ofs_code, 8'hA5);
  endtask

  task automatic t_csb_cut_read();
    logic [7:0] v; int drv; logic oe;
    frame(16'h8000, 12, 1'b1, 1'b0, v, drv, oe);
    check("R8 driving before cut", oe, 1'b1);
    csb_i = 1'b1; wt(5);
    check("R8 release on csb", sdio_oe, 1'b0);
    wt(HALF);
  endtask

  task automatic t_exit();
    logic [7:0] v; int drv; logic oe;
    wr(4'hF, 8'h00);
    rd(4'h0, v, drv, oe);
    check("R7 exit read mode", drv, 0);
  endtask

  task automatic t_abort();
    logic [7:0] v; int drv; logic oe;
    frame(16'h0177, 10, 1'b1, 1'b1, v, drv, oe);
    check("R4 aborted write", ofs_code, 8'hA5);
    wr(4'h1, 8'h5A);
    check("R11 restart after abort", ofs_code, 8'h5A);
  endtask

  task automatic t_abort_key();
    logic [7:0] v; int drv; logic oe;
    wr(4'hF, 8'hFE);
    frame(16'h0FED, 12, 1'b1, 1'b1, v, drv, oe);
    rd(4'h0, v, drv, oe);
    check("R12 aborted key no unlock", drv, 0);
    wr(4'hF, 8'hED);
    rd(4'h1, v, drv, oe);
    check("R12 key survives abort", v, 8'h5A);
    check("R12 key survives abort drv", drv, 8);
  endtask

  task automatic t_stream();
    logic [7:0] v; int drv; logic oe;
    frame(16'h0061, 16, 1'b1, 1'b0, v, drv, oe);
    frame(16'h0119, 16, 1'b0, 1'b0, v, drv, oe);
    frame(16'h8100, 16, 1'b0, 1'b1, v, drv, oe);
    check("R10 first frame", cfg_now(), 8'h61);
    check("R10 second frame", ofs_code, 8'h19);
    check("R10 third frame read", v, 8'h19);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_write();
    t_locked();
    t_bad_keys();
    t_unlock();
    t_unmapped();
    t_csb_cut_read();
    t_exit();
    t_abort();
    t_abort_key();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule